// File: doc/BRIEF.md
# Ethernet PAUSE Frame Request Controller

This block sits beside a MAC receive FIFO and decides when the transmitter must send an 802.3x flow-control (PAUSE) frame. It compares the FIFO fill level, counted in bytes, against two programmed thresholds that form a hysteresis band.

When the fill level climbs to the upper threshold, the block enters a congested state. It then asks a frame builder to send a PAUSE frame carrying the programmed initial quanta, normally 0xFFFF. While congestion lasts, a refresh timer counts 512-bit-time ticks from the MAC. After the programmed refresh interval, normally 0x7FFF, the block sends the request again. When the fill level drops below the lower threshold, the block leaves congestion and asks for one frame with zero quanta, which releases the link partner.

The frame builder sees a request/acknowledge pair: a request stays up, with its quanta stable, until the builder acknowledges it. A separate control output tells the receive MAC whether incoming PAUSE frames are to be discarded.

Top module: `pause_gen`

## Requirements
- R1: After reset the block is uncongested, `req` is low and `req_quanta` is 0.
- R2: When `tx_pause_en` is high, the block is uncongested and `fifo_bytes >= on_thresh`, the block becomes congested. On the next cycle `req` is high and `req_quanta` equals `init_quanta`.
- R3: A raised `req` stays high, with `req_quanta` unchanged, until `ack` is sampled high. After that it drops on the next cycle, unless a new event raises it again in that same cycle.
- R4: When `tx_pause_en` is high, the block is congested and `fifo_bytes < off_thresh`, the block leaves congestion. On the next cycle `req` is high and `req_quanta` is 0x0000.
- R5: While the fill level lies in the hysteresis band (at or above `off_thresh` when congested, below `on_thresh` when uncongested), the state does not change and no request is raised.
- R6: While congested with no request pending, each `quanta_tick` advances a refresh count. On the `refresh_quanta`-th such tick a new request with `init_quanta` is raised and the count restarts. A `refresh_quanta` of 0 disables refresh.
- R7: If congestion ends while a request is still pending, the pending quanta is replaced with 0. Only one frame is requested, and no further request follows its acknowledge.
- R8: While `tx_pause_en` is low, the congested state is cleared, the refresh count is cleared and no new request is raised.
- R9: `pause_ignore` is high exactly when `rx_pause_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_pause_en | input | 1 | Enables PAUSE generation |
| rx_pause_en | input | 1 | Obey received PAUSE frames |
| fifo_bytes | input | OCC_W | Receive FIFO fill level in bytes |
| on_thresh | input | OCC_W | Congestion entry level |
| off_thresh | input | OCC_W | Congestion exit level |
| init_quanta | input | QW | Quanta advertised in non-zero frames |
| refresh_quanta | input | QW | Refresh interval in quanta ticks |
| quanta_tick | input | 1 | One pulse per 512 bit times |
| ack | input | 1 | Frame builder accepted the request |
| req | output | 1 | PAUSE frame request |
| req_quanta | output | QW | Quanta for the requested frame |
| pause_ignore | output | 1 | Discard received PAUSE frames |

## Verification
The bench targets fill levels exactly at each threshold. A design that used a strict compare at entry or a non-strict one at exit would move the hysteresis edge and either miss a request or raise a spurious one. Congestion is ended while a request is still unacknowledged: a wrong design would send a stale 0xFFFF frame or queue a second frame after the zero one. The refresh count is run to its last tick, and also with a zero interval, where an off-by-one design requests a tick early or late and a design with no zero guard refreshes without end. Disabling transmit pause while the fill level is high must yield no frame at all.

// File: rtl/pause_gen.sv
module pause_gen #(
  parameter int OCC_W = 16,
  parameter int QW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_pause_en,
  input  logic             rx_pause_en,
  input  logic [OCC_W-1:0] fifo_bytes,
  input  logic [OCC_W-1:0] on_thresh,
  input  logic [OCC_W-1:0] off_thresh,
  input  logic [QW-1:0]    init_quanta,
  input  logic [QW-1:0]    refresh_quanta,
  input  logic             quanta_tick,
  input  logic             ack,
  output logic             req,
  output logic [QW-1:0]    req_quanta,
  output logic             pause_ignore
);
  logic          congested;
  logic [QW-1:0] cnt;

  wire enter   = !congested && (fifo_bytes >= on_thresh);
  wire leave   = congested && (fifo_bytes < off_thresh);
  wire counting = congested && !req && quanta_tick && (refresh_quanta != '0);
  wire last_tick = (cnt == refresh_quanta - 1'b1);

  assign pause_ignore = !rx_pause_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      congested  <= 1'b0;
      cnt        <= '0;
      req        <= 1'b0;
      req_quanta <= '0;
    end else begin
      if (ack) req <= 1'b0;
      if (!tx_pause_en) begin
        congested <= 1'b0;
        cnt       <= '0;
      end else if (enter) begin
        congested  <= 1'b1;
        req        <= 1'b1;
        req_quanta <= init_quanta;
        cnt        <= '0;
      end else if (leave) begin
        congested  <= 1'b0;
        req        <= 1'b1;
        req_quanta <= '0;
        cnt        <= '0;
      end else if (counting) begin
        if (last_tick) begin
          req        <= 1'b1;
          req_quanta <= init_quanta;
          cnt        <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pause_gen_chk.sv
module pause_gen_chk #(
  parameter int QW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_pause_en,
  input logic          ack,
  input logic          req,
  input logic [QW-1:0] req_quanta,
  input logic [QW-1:0] init_quanta,
  input logic          congested
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (req && !ack) |=> req); // R3
  AST_QUANTA_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> (req_quanta == $past(req_quanta)) || (req_quanta == '0) || (req_quanta == $past(init_quanta))); // R3
  AST_ENTRY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(congested) |-> (req && req_quanta == $past(init_quanta))); // R2
  AST_EXIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(congested) && $past(tx_pause_en)) |-> (req && req_quanta == '0)); // R4
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tx_pause_en) |-> !congested); // R8
endmodule

bind pause_gen pause_gen_chk #(.QW(QW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_pause_en(tx_pause_en), .ack(ack), .req(req),
  .req_quanta(req_quanta), .init_quanta(init_quanta), .congested(congested)
);

// File: tb/sim_pause_gen.sv
module sim_pause_gen;
  logic clk = 1'b0, rst_n = 1'b0, tx_en = 1'b0, rx_en = 1'b1, tick = 1'b0, ack = 1'b0;
  logic [15:0] occ = '0, on_t = '0, off_t = '0, initq = '0, refq = '0;
  logic req, ign;
  logic [15:0] q;
  int checks = 0, errors = 0;
  logic m_cong = 1'b0, m_req = 1'b0;
  logic [15:0] m_q = '0, m_cnt = '0;

  always #4 clk = ~clk;

  pause_gen u0 (.clk(clk), .rst_n(rst_n), .tx_pause_en(tx_en), .rx_pause_en(rx_en),
    .fifo_bytes(occ), .on_thresh(on_t), .off_thresh(off_t), .init_quanta(initq),
    .refresh_quanta(refq), .quanta_tick(tick), .ack(ack), .req(req),
    .req_quanta(q), .pause_ignore(ign));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_update();
    logic r0 = m_req;
    if (!rst_n) begin m_cong = 0; m_req = 0; m_q = 0; m_cnt = 0; return; end
    if (ack) m_req = 0;
    if (!tx_en) begin m_cong = 0; m_cnt = 0; end
    else if (!m_cong && occ >= on_t) begin m_cong = 1; m_req = 1; m_q = initq; m_cnt = 0; end
    else if (m_cong && occ < off_t) begin m_cong = 0; m_req = 1; m_q = 0; m_cnt = 0; end
    else if (m_cong && !r0 && tick && refq != 0) begin
      if (m_cnt == refq - 16'd1) begin m_req = 1; m_q = initq; m_cnt = 0; end
      else m_cnt = m_cnt + 16'd1;
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    chk("R3 model req", {31'd0, req}, {31'd0, m_req});
    if (m_req) chk("R2/R4/R6 model quanta", {16'd0, q}, {16'd0, m_q});
    chk("R9 ignore", {31'd0, ign}, {31'd0, !rx_en});
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    @(negedge clk);
    step(); step();
    chk("R1 reset req", {31'd0, req}, 32'd0);
    chk("R1 reset quanta", {16'd0, q}, 32'd0);
    rst_n = 1; tx_en = 1; on_t = 300; off_t = 100; initq = 16'hFFFF; refq = 3; occ = 299;
    step(); step();
    chk("R5 below entry", {31'd0, req}, 32'd0);
    occ = 300; step();
    chk("R2 entry req", {31'd0, req}, 32'd1);
    chk("R2 entry quanta", {16'd0, q}, 32'h0000FFFF);
    step(); step(); step();
    chk("R3 held", {31'd0, req}, 32'd1);
    ack = 1; step(); ack = 0;
    chk("R3 drop after ack", {31'd0, req}, 32'd0);
    occ = 100; step(); step();
    chk("R5 band no change", {31'd0, req}, 32'd0);
    tick = 1; step(); step();
    chk("R6 not yet", {31'd0, req}, 32'd0);
    step(); tick = 0;
    chk("R6 refresh req", {31'd0, req}, 32'd1);
    chk("R6 refresh quanta", {16'd0, q}, 32'h0000FFFF);
    occ = 99; step();
    chk("R7 replaced req", {31'd0, req}, 32'd1);
    chk("R7 replaced quanta zero", {16'd0, q}, 32'd0);
    occ = 50; ack = 1; step(); ack = 0; step(); step();
    chk("R7 single frame", {31'd0, req}, 32'd0);
    refq = 0; occ = 400; step(); ack = 1; step(); ack = 0; tick = 1;
    for (int i = 0; i < 10; i++) step();
    tick = 0;
    chk("R6 zero interval no refresh", {31'd0, req}, 32'd0);
    occ = 0; step(); ack = 1; step(); ack = 0;
    tx_en = 0; occ = 2000; rx_en = 0;
    for (int i = 0; i < 4; i++) step();
    chk("R8 disabled no req", {31'd0, req}, 32'd0);
    chk("R9 ignore set", {31'd0, ign}, 32'd1);
    rx_en = 1; tx_en = 1; on_t = 4608; off_t = 1536; refq = 5; initq = 16'h1234;
    for (int i = 0; i < 4000; i++) begin
      occ = 16'($urandom_range(0, 6200));
      tick = ($urandom_range(0, 2) == 0);
      ack = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 99) == 0) tx_en = !tx_en;
      rx_en = ($urandom_range(0, 7) != 0);
      step();
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end
endmodule